// File: doc/BRIEF.md
# Instruction Look-ahead Fetch Unit

This block is the front end of a 16-bit processor. It owns the instruction counter and a two-deep staging buffer: an execute register holding the word the decoder is working on, a look-ahead register holding the following word, and an immediate-data register. Sequential fetches run from the counter alone, so the arithmetic unit is never needed to step through the program. The block asks for a word whenever a staging slot is free and places each returned word in the first empty slot.

The decoder drives per-cycle flags for the instruction in the execute register: whether it is two words long and whether it carries an immediate operand. A long instruction occupies both staging registers. An instruction with an immediate has its operand moved out of the look-ahead slot into the immediate register, and that slot then refills with the next instruction while the operand stays put. A jump or branch loads a new counter value and flushes the buffer. On request, the counter value is copied to a link output so that control logic elsewhere can store a return address.

Top module: `lafetch_top`

## Requirements
- R1: During and directly after synchronous reset, the fetch address equals the parameter RESET_VEC, both staging valid flags are 0, ready_o is 0 and fetch_req_o is 1.
- R2: The counter rises by one in the cycle after a word is accepted (fetch_req_o and mem_valid_i high, redirect_i low). It loads redirect_addr_i in the cycle after redirect_i. In every other cycle it holds its value.
- R3: After redirect_i, both staging registers and the held-operand state are cleared. ready_o stays 0 until an execute word and a look-ahead word are both present.
- R4: An accepted word goes into the execute register when that register is empty, and into the look-ahead register otherwise. fetch_req_o is 1 exactly when at least one staging register is empty.
- R5: advance_i while ready_o is 1, with is_long_i at 0, moves the look-ahead word into the execute register and leaves the look-ahead register empty.
- R6: advance_i with both decoder flags at 0, a valid execute word, an empty look-ahead register and a word accepted in the same cycle puts that word straight into the execute register.
- R7: advance_i while ready_o is 1 and is_long_i is 1 empties both staging registers. ready_o is 1 only while both staging registers hold words.
- R8: While no operand is held, every word written into the look-ahead register is also written into the immediate register. When uses_imm_i is 1 with both registers full and no operand held, the look-ahead register is emptied in the next cycle and its word is held in the immediate register. That word does not change when the look-ahead register refills. While uses_imm_i is 1, ready_o needs the operand held. An advance releases it.
- R9: In the cycle after save_req_i, link_addr_o equals the fetch address of the request cycle. Otherwise link_addr_o holds its value.
- R10: advance_i when neither R5, R6 nor R7 applies has no effect on the staging registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| redirect_i | input | 1 | Jump or branch: load the counter and flush |
| redirect_addr_i | input | ADDR_W | Target address for redirect_i |
| mem_valid_i | input | 1 | Memory returns the word at fetch_addr_o this cycle |
| mem_data_i | input | WORD_W | Word returned by memory |
| advance_i | input | 1 | Decoder retires the executing instruction |
| is_long_i | input | 1 | Executing instruction spans two words |
| uses_imm_i | input | 1 | Executing instruction has an immediate operand |
| save_req_i | input | 1 | Copy the counter to link_addr_o |
| fetch_req_o | output | 1 | A staging slot is free |
| fetch_addr_o | output | ADDR_W | Instruction counter, address of the next fetch |
| exec_word_o | output | WORD_W | Execute register |
| exec_valid_o | output | 1 | Execute register holds a word |
| second_word_o | output | WORD_W | Look-ahead register |
| second_valid_o | output | 1 | Look-ahead register holds a word |
| imm_data_o | output | WORD_W | Immediate-data register |
| ready_o | output | 1 | Executing instruction is complete for the decoder |
| link_addr_o | output | ADDR_W | Saved counter value |

## Verification
On every cycle the assertions check the counter's step and load rules, that the look-ahead slot never holds a word while the execute slot is empty, that ready_o implies a full buffer, the operand hand-over into the immediate register, and the link capture. Only the bench's scenarios can show which words land in which slot across runs of fills, shifts, bypasses, long retirements and refills after a held operand. They also show that an advance without ready_o leaves the buffer untouched. A reference model in the bench follows each of these sequences under random stall and redirect patterns.

// File: rtl/lafetch_pkg.sv
package lafetch_pkg;
  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_FILL_EX,
    ACT_FILL_LA,
    ACT_TAKE_IMM,
    ACT_SHIFT,
    ACT_BYPASS,
    ACT_DROP_BOTH,
    ACT_FLUSH
  } step_e;
endpackage

// File: rtl/lafetch_pc.sv
module lafetch_pc #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              inc,
  output logic [ADDR_W-1:0] pc
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (rst)       pc <= RESET_VEC;
    else if (load) pc <= load_addr;
    else if (inc)  pc <= pc + STEP;
  end
endmodule

// File: rtl/lafetch_link.sv
module lafetch_link #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              save,
  input  logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] link
);
  always_ff @(posedge clk) begin
    if (rst)       link <= '0;
    else if (save) link <= pc;
  end
endmodule

// File: rtl/lafetch_ctrl.sv
module lafetch_ctrl
  import lafetch_pkg::*;
(
  input  logic  redirect,
  input  logic  mem_valid,
  input  logic  advance,
  input  logic  is_long,
  input  logic  uses_imm,
  input  logic  ex_v,
  input  logic  la_v,
  input  logic  held,
  output step_e act,
  output logic  fetch_req,
  output logic  word_in,
  output logic  ready
);
  logic plain;

  always_comb begin
    plain     = !is_long && !uses_imm;
    fetch_req = !(ex_v && la_v);
    word_in   = fetch_req && mem_valid && !redirect;
    ready     = ex_v && la_v && !(uses_imm && !held);

    if (redirect)                                   act = ACT_FLUSH;
    else if (advance && ready)                      act = is_long ? ACT_DROP_BOTH : ACT_SHIFT;
    else if (advance && ex_v && plain && !la_v && word_in)
                                                    act = ACT_BYPASS;
    else if (ex_v && la_v && uses_imm && !held)     act = ACT_TAKE_IMM;
    else if (word_in)                               act = ex_v ? ACT_FILL_LA : ACT_FILL_EX;
    else                                            act = ACT_IDLE;
  end
endmodule

// File: rtl/lafetch_buf.sv
module lafetch_buf
  import lafetch_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  step_e             act,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] ex_word,
  output logic              ex_v,
  output logic [WORD_W-1:0] la_word,
  output logic              la_v,
  output logic [WORD_W-1:0] imm_word,
  output logic              held
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ex_word  <= '0;
      la_word  <= '0;
      imm_word <= '0;
      ex_v     <= 1'b0;
      la_v     <= 1'b0;
      held     <= 1'b0;
    end else begin
      unique case (act)
        ACT_FLUSH, ACT_DROP_BOTH: begin
          ex_v <= 1'b0;
          la_v <= 1'b0;
          held <= 1'b0;
        end
        ACT_FILL_EX: begin
          ex_word <= din;
          ex_v    <= 1'b1;
        end
        ACT_FILL_LA: begin
          la_word <= din;
          la_v    <= 1'b1;
          if (!held) imm_word <= din;
        end
        ACT_TAKE_IMM: begin
          la_v <= 1'b0;
          held <= 1'b1;
        end
        ACT_SHIFT: begin
          ex_word <= la_word;
          la_v    <= 1'b0;
          held    <= 1'b0;
        end
        ACT_BYPASS: begin
          ex_word <= din;
          held    <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lafetch_top.sv
module lafetch_top
  import lafetch_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned WORD_W = 16,
  parameter logic [ADDR_W-1:0] RESET_VEC = ADDR_W'(16'h0100)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              redirect_i,
  input  logic [ADDR_W-1:0] redirect_addr_i,
  input  logic              mem_valid_i,
  input  logic [WORD_W-1:0] mem_data_i,
  input  logic              advance_i,
  input  logic              is_long_i,
  input  logic              uses_imm_i,
  input  logic              save_req_i,
  output logic              fetch_req_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic [WORD_W-1:0] exec_word_o,
  output logic              exec_valid_o,
  output logic [WORD_W-1:0] second_word_o,
  output logic              second_valid_o,
  output logic [WORD_W-1:0] imm_data_o,
  output logic              ready_o,
  output logic [ADDR_W-1:0] link_addr_o
);
  step_e act;
  logic  word_in;
  logic  held;

  lafetch_ctrl u_ctrl (
    .redirect  (redirect_i),
    .mem_valid (mem_valid_i),
    .advance   (advance_i),
    .is_long   (is_long_i),
    .uses_imm  (uses_imm_i),
    .ex_v      (exec_valid_o),
    .la_v      (second_valid_o),
    .held      (held),
    .act       (act),
    .fetch_req (fetch_req_o),
    .word_in   (word_in),
    .ready     (ready_o)
  );

  lafetch_pc #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_pc (
    .clk       (clk),
    .rst       (rst),
    .load      (redirect_i),
    .load_addr (redirect_addr_i),
    .inc       (word_in),
    .pc        (fetch_addr_o)
  );

  lafetch_buf #(.WORD_W(WORD_W)) u_buf (
    .clk      (clk),
    .rst      (rst),
    .act      (act),
    .din      (mem_data_i),
    .ex_word  (exec_word_o),
    .ex_v     (exec_valid_o),
    .la_word  (second_word_o),
    .la_v     (second_valid_o),
    .imm_word (imm_data_o),
    .held     (held)
  );

  lafetch_link #(.ADDR_W(ADDR_W)) u_link (
    .clk  (clk),
    .rst  (rst),
    .save (save_req_i),
    .pc   (fetch_addr_o),
    .link (link_addr_o)
  );
endmodule

// File: rtl/lafetch_chk.sv
module lafetch_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              redirect_i,
  input logic [ADDR_W-1:0] redirect_addr_i,
  input logic              mem_valid_i,
  input logic              advance_i,
  input logic              is_long_i,
  input logic              uses_imm_i,
  input logic              save_req_i,
  input logic              fetch_req_o,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic              exec_valid_o,
  input logic [WORD_W-1:0] second_word_o,
  input logic              second_valid_o,
  input logic [WORD_W-1:0] imm_data_o,
  input logic              ready_o,
  input logic [ADDR_W-1:0] link_addr_o
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (fetch_req_o && mem_valid_i && !redirect_i) |=> fetch_addr_o == $past(fetch_addr_o) + ONE);

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!(fetch_req_o && mem_valid_i) && !redirect_i) |=> $stable(fetch_addr_o));

  a_r3_flush: assert property (@(posedge clk) disable iff (rst)
    redirect_i |=> (!exec_valid_o && !second_valid_o && !ready_o
                    && fetch_addr_o == $past(redirect_addr_i)));

  a_r4_order: assert property (@(posedge clk) disable iff (rst)
    second_valid_o |-> exec_valid_o);

  a_r4_full_no_fetch: assert property (@(posedge clk) disable iff (rst)
    (exec_valid_o && second_valid_o) |-> !fetch_req_o);

  a_r7_ready_full: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> (exec_valid_o && second_valid_o));

  a_r8_take_imm: assert property (@(posedge clk) disable iff (rst)
    (exec_valid_o && second_valid_o && uses_imm_i && !is_long_i && !ready_o
     && !advance_i && !redirect_i)
    |=> (!second_valid_o && imm_data_o == $past(second_word_o)));

  a_r9_link: assert property (@(posedge clk) disable iff (rst)
    save_req_i |=> link_addr_o == $past(fetch_addr_o));

  a_r9_link_hold: assert property (@(posedge clk) disable iff (rst)
    !save_req_i |=> $stable(link_addr_o));
endmodule

bind lafetch_top lafetch_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .redirect_i      (redirect_i),
  .redirect_addr_i (redirect_addr_i),
  .mem_valid_i     (mem_valid_i),
  .advance_i       (advance_i),
  .is_long_i       (is_long_i),
  .uses_imm_i      (uses_imm_i),
  .save_req_i      (save_req_i),
  .fetch_req_o     (fetch_req_o),
  .fetch_addr_o    (fetch_addr_o),
  .exec_valid_o    (exec_valid_o),
  .second_word_o   (second_word_o),
  .second_valid_o  (second_valid_o),
  .imm_data_o      (imm_data_o),
  .ready_o         (ready_o),
  .link_addr_o     (link_addr_o)
);

// File: tb/lafetch_top_tb.sv
module lafetch_top_tb;
  localparam logic [15:0] RV = 16'h0100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        redirect = 1'b0;
  logic [15:0] redirect_addr = '0;
  logic        mem_valid = 1'b0;
  logic [15:0] mem_data;
  logic        advance = 1'b0;
  logic        is_long = 1'b0;
  logic        uses_imm = 1'b0;
  logic        save_req = 1'b0;
  logic        fetch_req, exec_valid, second_valid, ready;
  logic [15:0] fetch_addr, exec_word, second_word, imm_data, link_addr;

  int n_checks = 0;
  int n_fail   = 0;

  // model state
  logic [15:0] m_pc = RV, m_ex = '0, m_la = '0, m_di = '0, m_link = '0;
  logic        m_exv = 1'b0, m_lav = 1'b0, m_held = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [15:0] mem_word(input logic [15:0] a);
    return (a * 16'h9E37) ^ 16'h5A5A;
  endfunction

  assign mem_data = mem_word(fetch_addr);

  lafetch_top #(.ADDR_W(16), .WORD_W(16), .RESET_VEC(RV)) u_dut (
    .clk(clk), .rst(rst), .redirect_i(redirect), .redirect_addr_i(redirect_addr),
    .mem_valid_i(mem_valid), .mem_data_i(mem_data), .advance_i(advance),
    .is_long_i(is_long), .uses_imm_i(uses_imm), .save_req_i(save_req),
    .fetch_req_o(fetch_req), .fetch_addr_o(fetch_addr), .exec_word_o(exec_word),
    .exec_valid_o(exec_valid), .second_word_o(second_word), .second_valid_o(second_valid),
    .imm_data_o(imm_data), .ready_o(ready), .link_addr_o(link_addr)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare_model();
    logic rdy;
    rdy = m_exv && m_lav && !(uses_imm && !m_held);
    chk("R2 fetch_addr", fetch_addr, m_pc);
    chk("R4 fetch_req", {15'd0, fetch_req}, {15'd0, !(m_exv && m_lav)});
    chk("R4 exec_valid", {15'd0, exec_valid}, {15'd0, m_exv});
    if (m_exv) chk("R4 exec_word", exec_word, m_ex);
    chk("R5 second_valid", {15'd0, second_valid}, {15'd0, m_lav});
    if (m_lav) chk("R5 second_word", second_word, m_la);
    chk("R8 imm_data", imm_data, m_di);
    chk("R3 ready", {15'd0, ready}, {15'd0, rdy});
    chk("R9 link", link_addr, m_link);
  endtask

  task automatic model_next();
    logic freq, win, rdy, plain;
    logic [15:0] d;
    plain = !is_long && !uses_imm;
    freq  = !(m_exv && m_lav);
    win   = freq && mem_valid && !redirect;
    rdy   = m_exv && m_lav && !(uses_imm && !m_held);
    d     = mem_word(m_pc);
    if (save_req) m_link = m_pc;
    if (redirect) begin
      m_exv = 0; m_lav = 0; m_held = 0;
    end else if (advance && rdy) begin
      if (is_long) begin m_exv = 0; m_lav = 0; m_held = 0; end
      else begin m_ex = m_la; m_lav = 0; m_held = 0; end
    end else if (advance && m_exv && plain && !m_lav && win) begin
      m_ex = d; m_held = 0;
    end else if (m_exv && m_lav && uses_imm && !m_held) begin
      m_lav = 0; m_held = 1;
    end else if (win) begin
      if (!m_exv) begin m_ex = d; m_exv = 1; end
      else begin m_la = d; m_lav = 1; if (!m_held) m_di = d; end
    end
    if (redirect) m_pc = redirect_addr;
    else if (win) m_pc = m_pc + 16'd1;
  endtask

  task automatic step(input logic rd, input logic [15:0] tgt, input logic mv,
                      input logic adv, input logic lng, input logic imm, input logic sv);
    @(negedge clk);
    redirect = rd; redirect_addr = tgt; mem_valid = mv; advance = adv;
    is_long = lng; uses_imm = imm; save_req = sv;
    #1;
    compare_model();
    model_next();
  endtask

  task automatic settle();
    @(posedge clk); #1;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 fetch_addr", fetch_addr, RV);
    chk("R1 exec_valid", {15'd0, exec_valid}, 16'd0);
    chk("R1 second_valid", {15'd0, second_valid}, 16'd0);
    chk("R1 ready", {15'd0, ready}, 16'd0);
    chk("R1 fetch_req", {15'd0, fetch_req}, 16'd1);
    @(negedge clk);
    rst = 1'b0;

    step(1, 16'h2000, 1, 0, 0, 0, 0); settle();
    chk("R3 flush addr", fetch_addr, 16'h2000);
    chk("R3 flush valid", {15'd0, exec_valid}, 16'd0);
    step(0, 0, 1, 0, 0, 0, 0); settle();
    chk("R4 first word", exec_word, mem_word(16'h2000));
    chk("R3 not ready one word", {15'd0, ready}, 16'd0);
    step(0, 0, 1, 0, 0, 0, 0); settle();
    chk("R3 ready two words", {15'd0, ready}, 16'd1);
    chk("R4 second word", second_word, mem_word(16'h2001));
    step(0, 0, 1, 1, 0, 0, 0); settle();
    chk("R5 shift word", exec_word, mem_word(16'h2001));
    chk("R5 slot empty", {15'd0, second_valid}, 16'd0);
    chk("R2 no fetch when full", fetch_addr, 16'h2002);
    step(0, 0, 1, 1, 0, 0, 0); settle();
    chk("R6 bypass word", exec_word, mem_word(16'h2002));
    chk("R6 slot empty", {15'd0, second_valid}, 16'd0);
    step(0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0); settle();
    chk("R8 take operand", imm_data, mem_word(16'h2003));
    chk("R8 slot freed", {15'd0, second_valid}, 16'd0);
    step(0, 0, 1, 0, 0, 1, 0); settle();
    chk("R8 operand kept", imm_data, mem_word(16'h2003));
    chk("R8 refill", second_word, mem_word(16'h2004));
    chk("R8 ready held", {15'd0, ready}, 16'd1);
    step(0, 0, 0, 1, 0, 1, 0);
    step(0, 0, 1, 0, 0, 0, 0); settle();
    chk("R8 release copy", imm_data, mem_word(16'h2005));
    step(0, 0, 0, 1, 1, 0, 0); settle();
    chk("R7 drop both ex", {15'd0, exec_valid}, 16'd0);
    chk("R7 drop both la", {15'd0, second_valid}, 16'd0);
    step(0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 1, 1, 0, 0); settle();
    chk("R10 ignored advance word", exec_word, mem_word(16'h2006));
    chk("R10 ignored advance valid", {15'd0, exec_valid}, 16'd1);
    step(0, 0, 0, 0, 0, 0, 1); settle();
    chk("R9 link capture", link_addr, 16'h2007);

    begin
      int unused;
      unused = $urandom(32'h1750);
    end
    for (int i = 0; i < 4000; i++) begin
      logic rd, mv, adv, lng, imm, sv;
      logic [15:0] tgt;
      rd  = ($urandom % 100) < 3;
      tgt = 16'($urandom);
      mv  = ($urandom % 100) < 60;
      adv = ($urandom % 100) < 50;
      lng = ($urandom % 100) < 20;
      imm = !lng && (($urandom % 100) < 25);
      sv  = ($urandom % 100) < 10;
      if (i % 500 == 0) tgt = 16'hFFFF;
      step(rd, tgt, mv, adv, lng, imm, sv);
    end
    @(negedge clk);
    redirect = 0; mem_valid = 0; advance = 0; save_req = 0;
    #1;
    compare_model();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule